// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked, synthesizable model of a byte-wide memory whose bits can only be programmed once. It is meant to stand in for such a part inside a larger design or a system-level simulation. A parallel address bus selects a byte. A shared data bus is split into an input half, an output half and a drive-enable, so the surrounding logic can build the tri-state pad. Two active-low strobes, chip select and output gate, steer the block. Two digital flags replace the analog high voltages: one says the programming supply is present, and the other says a high voltage sits on address line 9.

From these inputs the block decodes the operating mode: plain read, idle, output off, program, program-verify, program-inhibit or identification. After reset the whole array reads as all ones. Programming can only move bits from 1 to 0, so each write stores the AND of the old byte and the new byte. In identification mode the block returns one of two fixed bytes, chosen by address bit 0. Every mode that drives the bus presents its byte one clock after the inputs are sampled.

The array holds 2^ADDR_W bytes. The default of 11 keeps elaboration small, and a full-size build sets ADDR_W to 15 for 32768 locations.

Top module: `otp_byte_store`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) data_oe is 0, and every location reads back as 8'hFF.
- R2: With vpp_on low and ce_n high, data_oe is 0 one clock later (idle).
- R3: With vpp_on low, ce_n low and oe_n high, data_oe is 0 one clock later (output off).
- R4: With vpp_on low, id_hv low and both ce_n and oe_n low, the next clock sets data_oe to 1 and data_out to the byte stored at addr.
- R5: A write commits at the first clock that samples ce_n high after a clock that sampled ce_n low, provided vpp_on is high and oe_n is high at both of those clocks. The write uses the addr and data_in sampled at that rising-edge clock. data_oe stays 0 whenever vpp_on and oe_n are both high.
- R6: A committed write stores the old byte AND data_in, so no bit ever returns from 0 to 1.
- R7: With vpp_on high, ce_n high and oe_n low, the next clock sets data_oe to 1 and data_out to the byte stored at addr (verify).
- R8: While vpp_on is high and ce_n stays high, changes on addr and data_in write nothing. When vpp_on is high and ce_n and oe_n are both low, data_oe is 0 and no write follows when ce_n rises.
- R9: With id_hv high, vpp_on low and both ce_n and oe_n low, the next clock sets data_oe to 1 and data_out to 8'h29 when addr[0] is 0, or to 8'h8C when addr[0] is 1, whatever the other address bits are.
- R10: id_hv has no effect while vpp_on is high, so verify with id_hv high still returns the stored byte.
- R11: All 2^ADDR_W locations are distinct: programming one address leaves an address that differs only in its top bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; sets the array to all ones |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Input half of the shared data bus (program data) |
| ce_n | input | 1 | Chip select, active low; a low pulse programs |
| oe_n | input | 1 | Output gate, active low |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | High voltage present on address line 9 |
| data_out | output | 8 | Output half of the shared data bus |
| data_oe | output | 1 | Drive enable for the data bus pad |

## Verification
The assertions assume that the strobes and flags change only between clock edges and that reset is held for at least one edge. The bus-quiet and identification checks look only at cycles where the previous edge was outside reset. The bench drives every input on the falling clock edge and keeps each programming pulse at least one full cycle low, so each rising edge of ce_n is seen at a distinct clock. The random phase picks among whole operations rather than raw pin values, and this keeps the strobe sequences inside the decoded modes. Directed cases add the one combination that no mode defines, which is ce_n and oe_n both low while the supply flag is set.

// File: rtl/otp_pkg.sv
// Package: shared types and constants for the one-time-programmable byte memory.
// Assumes: data bytes are 8 bits wide.
package otp_pkg;

    localparam int unsigned BYTE_W = 8;

    // Fixed identification bytes, selected by address bit 0.
    localparam logic [BYTE_W-1:0] ID_BYTE_LO = 8'h29;
    localparam logic [BYTE_W-1:0] ID_BYTE_HI = 8'h8C;

    // Operating modes decoded from strobes and voltage flags.
    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_OUTOFF  = 3'd1,
        MD_READ    = 3'd2,
        MD_IDENT   = 3'd3,
        MD_PROG    = 3'd4,
        MD_VERIFY  = 3'd5,
        MD_INHIBIT = 3'd6,
        MD_CLASH   = 3'd7
    } otp_mode_e;

endpackage

// File: rtl/otp_mode_decode.sv
// Module: otp_mode_decode
// Purpose: combinational decode of the operating mode from the two strobes
// and the two voltage flags.
// Assumes: inputs are already synchronous to the block clock. With the supply
// flag set, the identification flag is ignored.
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_on,
    input  logic      id_hv,
    output otp_mode_e mode
);

    // Mode table: the supply flag splits the programming group from the read group.
    always_comb begin
        if (vpp_on) begin
            unique case ({ce_n, oe_n})
                2'b01:   mode = MD_PROG;
                2'b10:   mode = MD_VERIFY;
                2'b11:   mode = MD_INHIBIT;
                default: mode = MD_CLASH;
            endcase
        end else if (ce_n) begin
            mode = MD_IDLE;
        end else if (oe_n) begin
            mode = MD_OUTOFF;
        end else if (id_hv) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/otp_prog_ctrl.sv
// Module: otp_prog_ctrl
// Purpose: finds the end of a programming pulse and issues a one-cycle write strobe.
// Assumes: a pulse counts only if the mode was program at the last low
// sample and is inhibit (supply on, both strobes high) at the rising sample.
module otp_prog_ctrl
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  otp_mode_e mode,
    input  logic      ce_n,
    input  logic      vpp_on,
    output logic      wr_en
);

    logic in_pulse_q;

    // Remember whether the last sampled cycle was inside a valid program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pulse_q <= 1'b0;
        end else begin
            in_pulse_q <= (mode == MD_PROG);
        end
    end

    // Strobe on the first high sample of chip select that ends a valid pulse.
    always_comb begin
        wr_en = in_pulse_q && (mode == MD_INHIBIT);
    end

    AST_WRITE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (vpp_on && ce_n && $past(!ce_n))); // R5

endmodule

// File: rtl/otp_cell_array.sv
// Module: otp_cell_array
// Purpose: byte storage that only clears bits. It is set to all ones on reset
// and has an asynchronous read port.
// Assumes: read and write share one address. A write in a cycle stores the
// AND of the current byte and the write data.
module otp_cell_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Reset fills the array with the erased value, and writes can only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wr_data;
        end
    end

    // Asynchronous read of the addressed byte.
    always_comb begin
        rd_data = cells[addr];
    end

    AST_NO_BIT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cells[$past(addr)] & ~$past(rd_data)) == '0)); // R6

    AST_ZERO_DATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cells[$past(addr)] & ~$past(wr_data)) == '0)); // R6

endmodule

// File: rtl/otp_out_stage.sv
// Module: otp_out_stage
// Purpose: registers the byte driven on the data bus and its drive enable.
// Assumes: the mode and array byte are stable before the clock edge. The
// output is quiet (zero, not driven) in every mode that does not drive.
module otp_out_stage
    import otp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  otp_mode_e         mode,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] arr_byte,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    logic [DATA_W-1:0] next_byte;
    logic              next_oe;

    // Choose the source of the next bus byte from the decoded mode.
    always_comb begin
        next_byte = '0;
        next_oe   = 1'b0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                next_byte = arr_byte;
                next_oe   = 1'b1;
            end
            MD_IDENT: begin
                next_byte = addr_lsb ? DATA_W'(ID_BYTE_HI) : DATA_W'(ID_BYTE_LO);
                next_oe   = 1'b1;
            end
            default: begin
                next_byte = '0;
                next_oe   = 1'b0;
            end
        endcase
    end

    // One-cycle response register for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else begin
            data_out <= next_byte;
            data_oe  <= next_oe;
        end
    end

    AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0)); // R2

endmodule

// File: rtl/otp_byte_store.sv
// Module: otp_byte_store (top)
// Purpose: clocked model of a byte-wide one-time-programmable memory with a
// split tri-state data bus, mode decode, program pulse detection and
// identification bytes.
// Assumes: the analog voltages reach it as digital flags and all inputs are
// synchronous. The array holds 2^ADDR_W bytes (15 for the full-size part).
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);

    otp_mode_e         mode;
    logic              wr_en;
    logic [BYTE_W-1:0] arr_byte;

    otp_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_on (vpp_on),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    otp_prog_ctrl u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .ce_n   (ce_n),
        .vpp_on (vpp_on),
        .wr_en  (wr_en)
    );

    otp_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (data_in),
        .rd_data (arr_byte)
    );

    otp_out_stage #(
        .DATA_W (BYTE_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .addr_lsb (addr[0]),
        .arr_byte (arr_byte),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    // Set once a full cycle has passed out of reset, so $past sees real inputs.
    logic chk_live;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_live <= 1'b0;
        end else begin
            chk_live <= 1'b1;
        end
    end

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(ce_n && !vpp_on)) |-> !data_oe); // R2

    AST_OUTOFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(oe_n && !vpp_on)) |-> !data_oe); // R3

    AST_PROG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(oe_n && vpp_on)) |-> !data_oe); // R5

    AST_CLASH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(vpp_on && !ce_n && !oe_n)) |-> !data_oe); // R8

    AST_IDENT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(id_hv && !vpp_on && !ce_n && !oe_n)) |->
        (data_oe && (data_out == ($past(addr[0]) ? ID_BYTE_HI : ID_BYTE_LO)))); // R9

endmodule

// File: tb/tb_otp_byte_store.sv
module tb_otp_byte_store;

    localparam int unsigned AW    = 11;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_on = 1'b0;
    logic          id_hv = 1'b0;
    logic [7:0]    data_out;
    logic          data_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] mdl [DEPTH];
    bit prev_pulse = 0;

    otp_byte_store #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on), .id_hv(id_hv),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #5 clk = ~clk;

    function automatic bit exp_drive(bit c, bit o, bit v);
        return (!v && !c && !o) || (v && c && !o);
    endfunction

    function automatic logic [7:0] exp_byte(bit v, bit h, logic [AW-1:0] a);
        if (!v && h) return a[0] ? 8'h8C : 8'h29;
        return mdl[a];
    endfunction

    task automatic check_out(string req, bit e_oe, logic [7:0] e_d);
        checks++;
        if (data_oe !== e_oe || (e_oe && data_out !== e_d)) begin
            fails++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                     req, data_oe, data_out, e_oe, e_d);
        end
    endtask

    // Drive one cycle of inputs, track the model, and check the registered response.
    task automatic cyc(bit c, bit o, bit v, bit h, logic [AW-1:0] a,
                       logic [7:0] d, string req);
        bit         e_oe;
        logic [7:0] e_d;
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_on = v; id_hv = h; addr = a; data_in = d;
        e_oe = exp_drive(c, o, v);
        e_d  = exp_byte(v, h, a);
        if (prev_pulse && v && c && o) mdl[a] = mdl[a] & d;
        prev_pulse = v && !c && o;
        @(posedge clk);
        #1;
        check_out(req, e_oe, e_d);
    endtask

    task automatic prog(logic [AW-1:0] a, logic [7:0] d, string req);
        cyc(0, 1, 1, 0, a, d, req);
        cyc(1, 1, 1, 0, a, d, req);
    endtask

    task automatic rd(logic [AW-1:0] a, string req);
        cyc(0, 0, 0, 0, a, 8'h00, req);
    endtask

    task automatic vfy(logic [AW-1:0] a, string req);
        cyc(1, 0, 1, 0, a, 8'h00, req);
    endtask

    task automatic expect_byte(logic [7:0] e, string req);
        checks++;
        if (data_out !== e) begin
            fails++;
            $display("FAIL %s: data=%h expected %h", req, data_out, e);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_out("R1 reset quiet", 1'b0, 8'h00);

        // R1 and R11: erased reads at the low, high and top addresses
        rd('0, "R1 erased");
        expect_byte(8'hFF, "R1 erased addr0");
        rd({AW{1'b1}}, "R1 erased top");

        // R2 idle, R3 output off
        cyc(1, 0, 0, 0, 11'd3, 8'h00, "R2 idle");
        cyc(1, 1, 0, 1, 11'd3, 8'h00, "R2 idle hv");
        cyc(0, 1, 0, 0, 11'd3, 8'h00, "R3 outoff");

        // R9 identity bytes; the upper address bits vary
        cyc(0, 0, 0, 1, 11'h4A0, 8'h00, "R9 ident lo");
        expect_byte(8'h29, "R9 ident lo");
        cyc(0, 0, 0, 1, 11'h7F1, 8'h00, "R9 ident hi");
        expect_byte(8'h8C, "R9 ident hi");

        // R5 and R7: program then verify
        prog(11'd5, 8'hA5, "R5 program");
        vfy(11'd5, "R7 verify");
        expect_byte(8'hA5, "R7 verify value");
        // R6: a second write only clears bits
        prog(11'd5, 8'h5F, "R6 reprogram");
        rd(11'd5, "R4 read after and");
        expect_byte(8'h05, "R6 and result");

        // R5: the address and data at the rising sample are the ones used
        cyc(0, 1, 1, 0, 11'd7, 8'h00, "R5 pulse low");
        cyc(1, 1, 1, 0, 11'd9, 8'h0F, "R5 rising");
        vfy(11'd9, "R5 edge addr");
        expect_byte(8'h0F, "R5 edge addr value");
        vfy(11'd7, "R5 low addr untouched");
        expect_byte(8'hFF, "R5 low addr untouched");

        // R8: supply on with chip select held high writes nothing
        for (int k = 0; k < 6; k++) begin
            cyc(1, 1, 1, 0, AW'(20 + k), 8'h00, "R8 inhibit");
        end
        for (int k = 0; k < 6; k++) begin
            vfy(AW'(20 + k), "R8 inhibit verify");
            expect_byte(8'hFF, "R8 inhibit value");
        end
        // R8: both strobes low with the supply on gives no drive and no write
        cyc(0, 0, 1, 0, 11'd30, 8'h00, "R8 clash quiet");
        cyc(1, 1, 1, 0, 11'd30, 8'h00, "R8 clash no write");
        vfy(11'd30, "R8 clash verify");
        expect_byte(8'hFF, "R8 clash value");

        // R10: the identification flag is ignored with the supply on
        cyc(1, 0, 1, 1, 11'd5, 8'h00, "R10 hv ignored");
        expect_byte(8'h05, "R10 stored byte");

        // R11: the top address bit selects a distinct location
        prog({1'b1, {(AW-1){1'b0}}} | 11'd5, 8'h00, "R11 program top");
        rd(11'd5, "R11 low alias");
        expect_byte(8'h05, "R11 low unchanged");
        rd({1'b1, {(AW-1){1'b0}}} | 11'd5, "R11 top");
        expect_byte(8'h00, "R11 top value");

        // Random mix of whole operations (R4 R6 R7 R9 among them)
        for (int n = 0; n < 1500; n++) begin
            logic [AW-1:0] a;
            int op;
            a  = AW'($urandom_range(0, 63));
            op = $urandom_range(0, 6);
            case (op)
                0: rd(a, "R4 random read");
                1: prog(a, 8'($urandom) & 8'($urandom), "R6 random program");
                2: vfy(a, "R7 random verify");
                3: cyc(0, 0, 0, 1, a, 8'h00, "R9 random ident");
                4: cyc(1, $urandom_range(0, 1) != 0, 0, 0, a, 8'h00, "R2 random idle");
                5: cyc(0, 1, 0, $urandom_range(0, 1) != 0, a, 8'h00, "R3 random outoff");
                default: cyc(1, 1, 1, 0, a, 8'($urandom), "R8 random inhibit");
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule